// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Responder

This block is a synthesizable, clock-sampled stand-in for an asynchronous static RAM that is 16 bits wide with two independently gated 8-bit lanes. It sits on the far side of a memory controller under test and answers that controller's pin-level traffic. On every rising edge of the sampling clock it reads the active-low control pins: select, write strobe, output gate, and the upper and lower lane enables. It then decides whether the part is idle, selected but silent, being read, or being written.

The data bus is split into an input byte pair, an output byte pair and one drive flag per lane. A testbench that joins these onto a shared bus can therefore see directly whether the responder and the controller drive the same lane at the same time. Nanosecond timing is reduced to whole sampling-clock cycles. A read result and its drive flags appear one cycle after the pins that ask for them.

A write lane opens only while select, write strobe and that lane's enable are all active. Its address and data are re-captured on every cycle the lane stays open. The array is updated on the edge at which any one of the three signals is first seen inactive, using the last captured values. The storage depth is 2^ADDR_W words, and ADDR_W = 16 gives the full 65536-word part.

The control path is a four-state machine, updated from the sampled pins on each edge:
- DESEL: select is inactive.
- QUIET: selected, but the output gate is off or both lanes are off.
- READ: selected, write strobe inactive, output gate on, and at least one lane on.
- WRITE: selected with the write strobe active.

Any state can move to any other on one edge. The transitions follow the priority select, then write strobe, then output gate and lane enables.

Top module: `sram_lane_model`

## Requirements
- R1: While ce_n is sampled high the machine enters DESEL, and in the following cycle dout_en is 2'b00 and dout is 0, whatever the other pins are.
- R2: When ce_n=0, we_n=1 and oe_n=0 are sampled and at least one lane enable is low, the machine enters READ. In the next cycle dout_en[0] equals the inverse of the sampled lb_n and dout_en[1] equals the inverse of the sampled ub_n. Each enabled lane carries the stored byte at the sampled address: bits 7:0 for the lower lane and bits 15:8 for the upper lane.
- R3: A lane whose dout_en bit is 0 shows 8'h00 on its dout bits.
- R4: With ce_n=0 and we_n=1, if oe_n is sampled high or both lane enables are sampled high, the machine enters QUIET and dout_en is 2'b00 in the next cycle.
- R5: With ce_n=0 and we_n=0 sampled, the machine enters WRITE and dout_en is 2'b00 in the next cycle, even when oe_n is low.
- R6: A write changes only the lanes whose enable was low while the write was open. The other byte of the same word keeps its old value.
- R7: A lane's write commits on the first edge at which ce_n, we_n or that lane's enable is sampled high after having been open. The update is visible to a read sampled on that same edge.
- R8: While a lane stays open, the address and data captured on the last open cycle are the ones stored. Earlier addresses seen during the window are left unchanged.
- R9: During reset the machine is in DESEL and dout_en is 2'b00.
- R10: The state follows the pins sampled on each edge with no stickiness. After a write closes into a read request, the next cycle already drives read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the control state |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| ub_n | input | 1 | Active-low upper lane enable (bits 15:8) |
| lb_n | input | 1 | Active-low lower lane enable (bits 7:0) |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data from the controller |
| dout | output | 16 | Read data, zero on lanes not driven |
| dout_en | output | 2 | Per-lane drive flags, bit 1 upper, bit 0 lower |

## Verification
The hardest condition to reach from the ports is a write window that closes on a lane enable while the other lane stays open. The two lanes must then commit on different edges, to different addresses, with different data. The stimulus holds the write strobe and select low over several cycles. It releases the lower enable first, then moves the address and data while only the upper lane is open, and finally releases the write strobe. Read-backs then confirm each lane's own last captured address and byte, and confirm that the intermediate address was untouched.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_QUIET = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } sram_state_e;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [LANES-1:0]    be_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [LANES-1:0]    lane_en
);

    sram_state_e state_q, state_d;
    logic [LANES-1:0] be_q;
    logic             past_ok;

    // next-state decode from the sampled pins, priority: select, strobe, gate
    always_comb begin
        if (ce_n)
            state_d = ST_DESEL;
        else if (!we_n)
            state_d = ST_WRITE;
        else if (oe_n || (&be_n))
            state_d = ST_QUIET;
        else
            state_d = ST_READ;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            be_q    <= '1;
            rd_addr <= '0;
            past_ok <= 1'b0;
        end else begin
            state_q <= state_d;
            be_q    <= be_n;
            rd_addr <= addr;
            past_ok <= 1'b1;
        end
    end

    // outputs per state
    always_comb begin
        unique case (state_q)
            ST_DESEL: lane_en = '0;
            ST_QUIET: lane_en = '0;
            ST_READ:  lane_en = ~be_q;
            ST_WRITE: lane_en = '0;
            default:  lane_en = '0;
        endcase
    end

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ce_n)) |-> (lane_en == '0));

    assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!ce_n && we_n && !oe_n)) |-> (lane_en == ~$past(be_n)));

    assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!ce_n && we_n && (oe_n || (&be_n)))) |-> (lane_en == '0));

    assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!ce_n && !we_n)) |-> (lane_en == '0));

endmodule

// File: rtl/sram_lane.sv
module sram_lane
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_sel,
    input  logic                lane_on,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [LANE_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic              open_now;
    logic              open_q;
    logic              commit;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANE_W-1:0] hold_data;

    assign open_now = wr_sel && lane_on;
    assign commit   = open_q && !open_now;

    // window tracking and capture of the last open cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            open_q <= open_now;
            if (open_now) begin
                hold_addr <= addr;
                hold_data <= wdata;
            end
        end
    end

    // array update on the closing edge
    always_ff @(posedge clk) begin
        if (commit)
            mem[hold_addr] <= hold_data;
    end

    assign rdata = mem[rd_addr];

    assert_commit_stores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (mem[$past(hold_addr)] == $past(hold_data)));

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        dout_en
);

    logic [LANES-1:0]  be_n;
    logic [ADDR_W-1:0] rd_addr;
    logic [LANES-1:0]  lane_en;
    logic              wr_sel;
    logic [LANE_W-1:0] lane_rd [LANES];

    assign be_n   = {ub_n, lb_n};
    assign wr_sel = !ce_n && !we_n;

    sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .be_n    (be_n),
        .addr    (addr),
        .rd_addr (rd_addr),
        .lane_en (lane_en)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sram_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel),
            .lane_on (!be_n[i]),
            .addr    (addr),
            .wdata   (din[i*LANE_W +: LANE_W]),
            .rd_addr (rd_addr),
            .rdata   (lane_rd[i])
        );
        assign dout[i*LANE_W +: LANE_W] = lane_en[i] ? lane_rd[i] : '0;
    end

    assign dout_en = lane_en;

endmodule

// File: tb/sram_lane_model_bench.sv
module sram_lane_model_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_model #(.ADDR_W(AW)) u_sram_lane_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        logic [1:0]  en;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;

    // reference state built from the requirements
    logic [7:0]    shadow [2][1 << AW];
    logic [1:0]    ref_open = 2'b00;
    logic [AW-1:0] ref_haddr [2];
    logic [7:0]    ref_hdata [2];

    // monitor: compares one expected item per cycle, away from the rising edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (dout_en !== e.en || dout !== e.data) begin
                n_fail++;
                $display("FAIL %s: actual en=%b data=%h expected en=%b data=%h",
                         e.tag, dout_en, dout, e.en, e.data);
            end
        end
    end

    // driver: one sampled cycle, the reference model predicts the next outputs
    task automatic cyc(input logic c, input logic w, input logic o,
                       input logic u, input logic l,
                       input logic [AW-1:0] a, input logic [15:0] d,
                       input string tag);
        exp_t e;
        logic [1:0] be;
        @(negedge clk);
        #1;
        ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; din = d;
        be = {u, l};
        for (int i = 0; i < 2; i++) begin
            logic now_open;
            now_open = !c && !w && !be[i];
            if (ref_open[i] && !now_open)
                shadow[i][ref_haddr[i]] = ref_hdata[i];
            if (now_open) begin
                ref_haddr[i] = a;
                ref_hdata[i] = d[i*8 +: 8];
            end
            ref_open[i] = now_open;
        end
        e.en   = (!c && w && !o) ? ~be : 2'b00;
        e.data = 16'h0000;
        for (int i = 0; i < 2; i++)
            if (e.en[i]) e.data[i*8 +: 8] = shadow[i][a];
        e.tag = tag;
        @(posedge clk);
        exp_q.push_back(e);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still active expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        n_tests++;
        if (dout_en !== 2'b00 || dout !== 16'h0) begin
            n_fail++;
            $display("FAIL R9: actual en=%b data=%h expected en=00 data=0000", dout_en, dout);
        end
        rst_n = 1'b1;

        // R8 + R7: full word written, data changes mid-window, closed by we_n
        cyc(0,0,1,0,0, 10'd5, 16'h1111, "R5 write open");
        cyc(0,0,0,0,0, 10'd5, 16'hA5C3, "R5 write with oe low");
        cyc(0,1,0,0,0, 10'd5, 16'h0000, "R7 close by we, R10 read same edge");
        cyc(0,1,0,0,0, 10'd5, 16'h0000, "R2 full read");

        // R6: lower-only overwrite keeps upper
        cyc(0,0,1,0,0, 10'd6, 16'h2233, "R6 seed word");
        cyc(1,1,1,1,1, 10'd6, 16'h0000, "R1 deselect closes write");
        cyc(0,0,1,1,0, 10'd6, 16'hEEAB, "R6 lower-only open");
        cyc(0,1,0,0,0, 10'd6, 16'h0000, "R6 read merged word");

        // R7: close by ce_n
        cyc(0,0,1,0,0, 10'd7, 16'h7788, "R7 open");
        cyc(1,0,1,0,0, 10'd7, 16'h0000, "R7 close by ce, R1");
        cyc(0,1,0,0,0, 10'd7, 16'h0000, "R7 read after ce close");

        // R7/R8: lanes closing on different edges, address moves mid-window
        cyc(0,0,1,0,0, 10'd20, 16'h4455, "R8 both open at 20");
        cyc(0,0,1,1,1, 10'd20, 16'h0000, "R7 both closed by lane enables");
        cyc(0,0,1,0,0, 10'd30, 16'h9911, "R8 both open at 30");
        cyc(0,0,1,0,1, 10'd31, 16'h9A00, "R7 lower closes, upper moves to 31");
        cyc(0,0,1,0,1, 10'd32, 16'hBC00, "R8 upper moves to 32");
        cyc(0,1,1,1,1, 10'd0,  16'h0000, "R4 quiet, upper closes");
        cyc(0,1,0,0,0, 10'd30, 16'h0000, "R8 read 30");
        cyc(0,1,0,0,0, 10'd31, 16'h0000, "R8 read 31");
        cyc(0,1,0,0,0, 10'd32, 16'h0000, "R8 read 32");
        cyc(0,1,0,0,0, 10'd20, 16'h0000, "R7 read 20");

        // R2/R3: single-lane reads
        cyc(0,1,0,0,1, 10'd5, 16'h0000, "R3 upper lane only");
        cyc(0,1,0,1,0, 10'd5, 16'h0000, "R3 lower lane only");

        // R4: gate off, both lanes off
        cyc(0,1,1,0,0, 10'd5, 16'h0000, "R4 oe high");
        cyc(0,1,0,1,1, 10'd5, 16'h0000, "R4 both lanes off");

        // R1: deselect with read-like pins
        cyc(1,1,0,0,0, 10'd5, 16'h0000, "R1 deselect read pins");

        // R5: write strobe low, no lanes, must not alter memory
        cyc(0,0,0,1,1, 10'd5, 16'hFFFF, "R5 strobe no lanes");
        cyc(0,1,0,0,0, 10'd5, 16'h0000, "R6 word unchanged");
        cyc(1,1,1,1,1, 10'd0, 16'h0000, "R1 idle");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule